// File: doc/BRIEF.md
# Cascaded Eight-Bit Magnitude Comparator

This block compares two unsigned operands and raises one of three flags: equal, greater-than (first operand larger) or less-than (second operand larger). It has no registers: the flags follow the inputs within the same cycle. A caller uses it wherever a single combinational ordering decision is needed, for example to pick a winner or to test a bound.

The comparison is split into identical four-bit slices. Each slice finds its own ordering bit by bit, starting at its most significant bit. A priority chain then combines the slices. The more significant slice sets the result whenever its nibbles differ. Only when its nibbles match does the verdict pass to the slice below.

An output-enable input gates the combined result. When the enable is low, all three flags are held at 0 whatever the operands are.

Top module: `mag_cmp8`

## Requirements
- R1: With `oe_i`=1, `eq_o` is 1 exactly when `a_i` equals `b_i`. Equality is the AND of bitwise XNORs and matches the case where neither ordering flag is set.
- R2: With `oe_i`=1, `gt_o` is 1 exactly when `a_i` > `b_i`, treating both operands as unsigned.
- R3: With `oe_i`=1, `lt_o` is 1 exactly when `a_i` < `b_i`, treating both operands as unsigned.
- R4: When the upper nibbles (bits 7:4) differ, they alone decide the result, whatever bits 3:0 hold. For example, 0x1F against 0x20 gives less-than.
- R5: When the upper nibbles are equal, the lower nibbles (bits 3:0) decide the result. For example, 0x35 against 0x3A gives less-than.
- R6: With `oe_i`=0, `eq_o`, `gt_o` and `lt_o` are all 0 for every operand pair.
- R7: With `oe_i`=1, exactly one of the three flags is 1 for every operand pair.
- R8: The extreme operand values 0x00 and 0xFF compare correctly in every pairing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 8 | First operand, unsigned |
| b_i | input | 8 | Second operand, unsigned |
| oe_i | input | 1 | Output enable; 0 forces all flags low |
| eq_o | output | 1 | Operands are equal |
| gt_o | output | 1 | First operand is greater |
| lt_o | output | 1 | First operand is smaller |

## Verification
Two functions can act on the flags in the same evaluation: the upper-slice priority override and the enable gate. Both can also meet a lower slice that disagrees with the upper slice.

The table drives operand pairs in which the two nibbles point in opposite directions. One example is 0x1F against 0x20, where the lower nibble alone would say greater. The same pairs are driven again with the enable low.

Each result is judged against an unsigned comparison computed in the bench. The bench also checks that the disabled rows return all zeros, even for pairs whose enabled result is an ordering flag.

// File: rtl/mag_cmp_pkg.sv
package mag_cmp_pkg;
  typedef struct packed {
    logic eq;
    logic gt;
    logic lt;
  } cmp_flags_t;
endpackage

// File: rtl/mag_cmp_slice.sv
module mag_cmp_slice
  import mag_cmp_pkg::*;
#(
  parameter int SW = 4
) (
  input  logic [SW-1:0] a,
  input  logic [SW-1:0] b,
  output cmp_flags_t    flags
);
  logic gt_s, lt_s;

  // scan from the most significant bit; the first differing bit decides
  always_comb begin
    logic found;
    found = 1'b0;
    gt_s  = 1'b0;
    lt_s  = 1'b0;
    for (int i = SW - 1; i >= 0; i--) begin
      if (!found && (a[i] != b[i])) begin
        gt_s  = a[i];
        lt_s  = b[i];
        found = 1'b1;
      end
    end
  end

  assign flags.gt = gt_s;
  assign flags.lt = lt_s;
  assign flags.eq = ~(gt_s | lt_s);

  // R1: ordering-derived equality must agree with XNOR-reduction equality
  always_comb begin
    p_slice_eq_xnor_r1: assert (flags.eq == (&(a ~^ b)));
    p_slice_onehot_r7: assert ($countones({flags.eq, flags.gt, flags.lt}) == 1);
  end
endmodule

// File: rtl/mag_cmp_merge.sv
module mag_cmp_merge
  import mag_cmp_pkg::*;
(
  input  cmp_flags_t hi,
  input  cmp_flags_t lo,
  output cmp_flags_t res
);
  always_comb begin
    if (hi.eq) res = lo;
    else       res = hi;
  end

  // R4: an unequal upper slice must pass through unchanged
  always_comb begin
    if (!hi.eq) begin
      p_hi_priority_r4: assert (res.gt == hi.gt && res.lt == hi.lt && !res.eq);
    end
    if (hi.eq) begin
      p_lo_decides_r5: assert (res.gt == lo.gt && res.lt == lo.lt);
    end
  end
endmodule

// File: rtl/mag_cmp_gate.sv
module mag_cmp_gate
  import mag_cmp_pkg::*;
(
  input  cmp_flags_t din,
  input  logic       oe,
  output cmp_flags_t dout
);
  assign dout = oe ? din : '0;
endmodule

// File: rtl/mag_cmp8.sv
module mag_cmp8
  import mag_cmp_pkg::*;
#(
  parameter int W  = 8,
  parameter int SW = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         oe_i,
  output logic         eq_o,
  output logic         gt_o,
  output logic         lt_o
);
  localparam int NSL = W / SW;

  cmp_flags_t sl    [NSL];
  cmp_flags_t chain [NSL];
  cmp_flags_t gated;

  for (genvar g = 0; g < NSL; g++) begin : g_slice
    mag_cmp_slice #(.SW(SW)) u_slice (
      .a     (a_i[g*SW +: SW]),
      .b     (b_i[g*SW +: SW]),
      .flags (sl[g])
    );
  end

  assign chain[0] = sl[0];
  for (genvar g = 1; g < NSL; g++) begin : g_chain
    mag_cmp_merge u_merge (
      .hi  (sl[g]),
      .lo  (chain[g-1]),
      .res (chain[g])
    );
  end

  mag_cmp_gate u_gate (
    .din  (chain[NSL-1]),
    .oe   (oe_i),
    .dout (gated)
  );

  assign eq_o = gated.eq;
  assign gt_o = gated.gt;
  assign lt_o = gated.lt;

  always_comb begin
    if (!oe_i) begin
      p_oe_off_r6: assert ({eq_o, gt_o, lt_o} == 3'b000);
    end else begin
      p_onehot_r7: assert ($countones({eq_o, gt_o, lt_o}) == 1);
      p_eq_match_r1: assert (eq_o == (a_i == b_i));
    end
  end
endmodule

// File: tb/sim_mag_cmp8.sv
`timescale 1ns/1ps
module sim_mag_cmp8;
  logic       clk;
  logic [7:0] a, b;
  logic       oe;
  logic       eq, gt, lt;
  int         n_chk, n_bad;
  bit         done;

  // {a, b, oe, eq, gt, lt}
  localparam logic [19:0] VEC [12] = '{
    {8'h00, 8'h00, 1'b1, 3'b100},  // R8
    {8'hFF, 8'hFF, 1'b1, 3'b100},  // R8
    {8'h00, 8'hFF, 1'b1, 3'b001},  // R8
    {8'hFF, 8'h00, 1'b1, 3'b010},  // R8
    {8'h1F, 8'h20, 1'b1, 3'b001},  // R4
    {8'h20, 8'h1F, 1'b1, 3'b010},  // R4
    {8'h35, 8'h3A, 1'b1, 3'b001},  // R5
    {8'h3A, 8'h35, 1'b1, 3'b010},  // R5
    {8'h80, 8'h7F, 1'b1, 3'b010},  // R2
    {8'hA5, 8'hA5, 1'b0, 3'b000},  // R6
    {8'hFF, 8'h00, 1'b0, 3'b000},  // R6
    {8'h1F, 8'h20, 1'b0, 3'b000}   // R6
  };

  mag_cmp8 u0 (
    .a_i  (a),
    .b_i  (b),
    .oe_i (oe),
    .eq_o (eq),
    .gt_o (gt),
    .lt_o (lt)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [2:0] exp);
    n_chk++;
    if ({eq, gt, lt} !== exp) begin
      n_bad++;
      $display("FAIL %s a=%h b=%h oe=%b actual=%b expected=%b",
               req, a, b, oe, {eq, gt, lt}, exp);
    end
  endtask

  task automatic apply(input logic [7:0] av, input logic [7:0] bv, input logic ov,
                       input string req, input logic [2:0] exp);
    @(posedge clk);
    a  = av;
    b  = bv;
    oe = ov;
    @(negedge clk);
    check(req, exp);
  endtask

  function automatic logic [2:0] model(input logic [7:0] av, input logic [7:0] bv,
                                       input logic ov);
    if (!ov) return 3'b000;
    return {av == bv, av > bv, av < bv};
  endfunction

  initial begin
    n_chk = 0;
    n_bad = 0;
    done  = 1'b0;
    a  = 8'h00;
    b  = 8'h00;
    oe = 1'b0;
    @(negedge clk);
    check("R6 initial disabled", 3'b000);

    for (int i = 0; i < 12; i++) begin
      apply(VEC[i][19:12], VEC[i][11:4], VEC[i][3], "R1/R2/R3 table", VEC[i][2:0]);
    end

    // R1 R2 R3 R7: strided sweep against an unsigned model
    for (int i = 0; i < 256; i += 7) begin
      for (int j = 0; j < 256; j += 5) begin
        apply(i[7:0], j[7:0], 1'b1, "R7 sweep", model(i[7:0], j[7:0], 1'b1));
      end
    end

    // R5: equal upper nibble, every lower pairing
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        apply({4'h9, i[3:0]}, {4'h9, j[3:0]}, 1'b1, "R5 lower decides",
              model({4'h9, i[3:0]}, {4'h9, j[3:0]}, 1'b1));
      end
    end

    // R4: upper nibble differs, lower nibble points the other way
    for (int i = 0; i < 15; i++) begin
      apply({i[3:0], 4'hF}, {i[3:0] + 4'd1, 4'h0}, 1'b1, "R4 upper priority", 3'b001);
      apply({i[3:0] + 4'd1, 4'h0}, {i[3:0], 4'hF}, 1'b1, "R4 upper priority", 3'b010);
    end

    // R6: enable low across a sweep
    for (int i = 0; i < 256; i += 17) begin
      apply(i[7:0], 8'd255 - i[7:0], 1'b0, "R6 disabled", 3'b000);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule